// File: doc/BRIEF.md
# Fused multiply-accumulate compression tree

This combinational block forms one W-bit total from several product terms and several plain addends. Each term carries its own signedness flag and its own subtract flag. A product that is added is not computed on its own. Its partial-product rows join the addend rows in one shared carry-save reduction, and a single carry-propagate adder produces the result.

A subtracted product takes a separate path. Its rows are reduced and added to form the full product, and that product is inverted and enters the shared pool as one row. Every inverted row, whether from a product or from an addend, needs a +1. Each signed product that is fused into the pool also needs a +1. All of these are gathered into a single constant row.

A parameter can switch fusion off. Every product is then formed in full before accumulation. Further parameters choose the compressor style of the shared tree and the width below which the final adder is a ripple chain rather than a parallel prefix network.

The block has no clock. A consumer samples `total` once the inputs have been stable for the combinational delay.

Top module: `fmac_tree`

## Requirements
- R1: `total` equals the sum over products k of (±`mul_x`[k]·`mul_y`[k]) plus the sum over addends m of (±`addend`[m]), taken modulo 2^W. Product k occupies bits [k·FW +: FW] of `mul_x` and `mul_y`. Addend m occupies bits [m·AW +: AW] of `addend`.
- R2: `mul_signed`[k]=1 makes both factors of product k two's-complement, and the most-negative value −2^(FW−1) is included. When the flag is 0, both factors are unsigned.
- R3: `addend_signed`[m]=1 sign-extends addend m to W bits. When the flag is 0, the addend is zero-extended.
- R4: `mul_neg`[k]=1 subtracts product k and `addend_neg`[m]=1 subtracts addend m. When the flag is 0, the term is added.
- R5: every bit of weight 2^W or above is discarded, so the sum wraps modulo 2^W.
- R6: the pool row of a subtracted product is the bitwise complement of that product taken modulo 2^W.
- R7: with fusion disabled (FUSE=0), the result is the same as in R1 for the same inputs.
- R8: the carry-save reduction keeps the sum of its rows modulo 2^W unchanged. This holds both with 4:2 compressors preferred and with 3:2 compressors only.
- R9: the final adder is a ripple chain when W < RIPPLE_BELOW and a prefix network otherwise. In both cases `total` equals the sum of the two reduced rows.
- R10: when all values are zero, `total` is zero whatever the subtract and sign flags, so the correction constant cancels exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mul_x | input | NP*FW | First factor of each product term, packed |
| mul_y | input | NP*FW | Second factor of each product term, packed |
| mul_signed | input | NP | Per-product two's-complement flag for both factors |
| mul_neg | input | NP | Per-product subtract flag |
| addend | input | NA*AW | Plain addend terms, packed |
| addend_signed | input | NA | Per-addend sign-extension flag |
| addend_neg | input | NA | Per-addend subtract flag |
| total | output | W | Sum modulo 2^W |

## Verification
The bench builds two instances and drives both with the same stimulus.

- The first uses W=16, FUSE=1 and prefers 4:2 compressors, so its final adder is the prefix network.
- The second uses W=12, FUSE=0, 3:2 compressors only and a ripple final adder.

Together they cover both compressor strategies, both final adders, and the fused and unfused product paths. At 12 bits, products of extreme factors overflow, which exercises the modulo-2^W wraparound of R5 that the 16-bit instance rarely sees.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

  // Rows left after one reduction level.
  function automatic int rows_after(int rin, int pref42);
    int q;
    int r;
    if (rin <= 2) return rin;
    if (pref42 != 0) begin
      q = rin / 4;
      r = rin % 4;
      return 2 * q + ((r == 3) ? 2 : r);
    end
    return 2 * (rin / 3) + (rin % 3);
  endfunction

  // Number of levels until two rows remain.
  function automatic int level_count(int rin, int pref42);
    int n;
    int c;
    n = rin;
    c = 0;
    while (n > 2) begin
      n = rows_after(n, pref42);
      c++;
    end
    return c;
  endfunction

  // Rows entering a given level.
  function automatic int rows_at(int rin, int pref42, int lvl);
    int n;
    n = rin;
    for (int i = 0; i < lvl; i++) n = rows_after(n, pref42);
    return n;
  endfunction

endpackage

// File: rtl/fmac_ppgen.sv
// Partial-product rows of one FW x FW product, at result width W.
// Signed mode: the top row is inverted; the caller adds +1 elsewhere.
module fmac_ppgen #(
  parameter int W  = 16,
  parameter int FW = 8
) (
  input  logic [FW-1:0]         x,
  input  logic [FW-1:0]         y,
  input  logic                  sgn,
  output logic [FW-1:0][W-1:0]  rows
);
  logic [W-1:0] y_ext;
  logic [W-1:0] top_row;

  always_comb begin
    y_ext = '0;
    y_ext[FW-1:0] = y;
    for (int i = FW; i < W; i++) y_ext[i] = sgn & y[FW-1];
  end

  always_comb begin
    for (int i = 0; i < FW - 1; i++)
      rows[i] = x[i] ? (y_ext << i) : '0;
    top_row = x[FW-1] ? (y_ext << (FW - 1)) : '0;
    rows[FW-1] = sgn ? ~top_row : top_row;
  end
endmodule

// File: rtl/fmac_csa_level.sv
// One reduction level: 4:2 groups (optional), 3:2 groups, pass-through.
module fmac_csa_level #(
  parameter int W      = 16,
  parameter int RIN    = 4,
  parameter int PREF42 = 1,
  localparam int ROUT  = fmac_pkg::rows_after(RIN, PREF42)
) (
  input  logic [RIN-1:0][W-1:0]  din,
  output logic [ROUT-1:0][W-1:0] dout
);
  localparam int NQ    = (PREF42 != 0) ? RIN / 4 : 0;
  localparam int REM   = RIN - 4 * NQ;
  localparam int NT    = (PREF42 != 0) ? ((REM == 3) ? 1 : 0) : RIN / 3;
  localparam int NPASS = RIN - 4 * NQ - 3 * NT;
  localparam int TIN   = 4 * NQ;
  localparam int PIN   = 4 * NQ + 3 * NT;
  localparam int TOUT  = 2 * NQ;
  localparam int POUT  = 2 * NQ + 2 * NT;

  function automatic logic [W-1:0] maj(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  for (genvar q = 0; q < NQ; q++) begin : g_quad
    logic [W-1:0] s1;
    logic [W-1:0] c1;
    assign s1 = din[4*q] ^ din[4*q+1] ^ din[4*q+2];
    assign c1 = maj(din[4*q], din[4*q+1], din[4*q+2]) << 1;
    assign dout[2*q]   = s1 ^ din[4*q+3] ^ c1;
    assign dout[2*q+1] = maj(s1, din[4*q+3], c1) << 1;
  end

  for (genvar t = 0; t < NT; t++) begin : g_tri
    assign dout[TOUT+2*t]   = din[TIN+3*t] ^ din[TIN+3*t+1] ^ din[TIN+3*t+2];
    assign dout[TOUT+2*t+1] = maj(din[TIN+3*t], din[TIN+3*t+1], din[TIN+3*t+2]) << 1;
  end

  for (genvar p = 0; p < NPASS; p++) begin : g_pass
    assign dout[POUT+p] = din[PIN+p];
  end
endmodule

// File: rtl/fmac_csa_tree.sv
// Carry-save reduction of ROWS rows down to a sum row and a carry row.
module fmac_csa_tree #(
  parameter int W      = 16,
  parameter int ROWS   = 5,
  parameter int PREF42 = 1
) (
  input  logic [ROWS-1:0][W-1:0] rows,
  output logic [W-1:0]           row_s,
  output logic [W-1:0]           row_c
);
  localparam int NLV = fmac_pkg::level_count(ROWS, PREF42);

  for (genvar l = 0; l < NLV; l++) begin : g_lv
    localparam int RIN  = fmac_pkg::rows_at(ROWS, PREF42, l);
    localparam int ROUT = fmac_pkg::rows_after(RIN, PREF42);
    logic [RIN-1:0][W-1:0]  din;
    logic [ROUT-1:0][W-1:0] dout;
    if (l == 0) begin : g_first
      assign din = rows;
    end else begin : g_next
      assign din = g_lv[l-1].dout;
    end
    fmac_csa_level #(.W(W), .RIN(RIN), .PREF42(PREF42)) u_level (
      .din (din),
      .dout(dout)
    );
  end

  if (NLV == 0) begin : g_short
    assign row_s = rows[0];
    if (ROWS > 1) begin : g_two
      assign row_c = rows[1];
    end else begin : g_one
      assign row_c = '0;
    end
  end else begin : g_long
    assign row_s = g_lv[NLV-1].dout[0];
    assign row_c = g_lv[NLV-1].dout[1];
  end
endmodule

// File: rtl/fmac_cpa.sv
// Final two-operand adder, result truncated to W bits.
module fmac_cpa #(
  parameter int W            = 16,
  parameter int RIPPLE_BELOW = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  if (W < RIPPLE_BELOW) begin : g_ripple
    always_comb begin
      logic c;
      c = 1'b0;
      for (int i = 0; i < W; i++) begin
        s[i] = x[i] ^ y[i] ^ c;
        c = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
      end
    end
  end else begin : g_prefix
    // Kogge-Stone style generate/propagate combining.
    always_comb begin
      logic [W-1:0] gg;
      logic [W-1:0] pp;
      logic [W-1:0] gn;
      logic [W-1:0] pn;
      logic [W-1:0] half;
      gg = x & y;
      pp = x ^ y;
      half = pp;
      for (int d = 1; d < W; d = d * 2) begin
        gn = gg;
        pn = pp;
        for (int i = d; i < W; i++) begin
          gn[i] = gg[i] | (pp[i] & gg[i-d]);
          pn[i] = pp[i] & pp[i-d];
        end
        gg = gn;
        pp = pn;
      end
      s = half ^ (gg << 1);
    end
  end
endmodule

// File: rtl/fmac_tree.sv
module fmac_tree #(
  parameter int W            = 16,
  parameter int NP           = 2,
  parameter int FW           = 8,
  parameter int NA           = 2,
  parameter int AW           = 12,
  parameter int FUSE         = 1,
  parameter int PREF42       = 1,
  parameter int RIPPLE_BELOW = 16
) (
  input  logic [NP*FW-1:0] mul_x,
  input  logic [NP*FW-1:0] mul_y,
  input  logic [NP-1:0]    mul_signed,
  input  logic [NP-1:0]    mul_neg,
  input  logic [NA*AW-1:0] addend,
  input  logic [NA-1:0]    addend_signed,
  input  logic [NA-1:0]    addend_neg,
  output logic [W-1:0]     total
);
  localparam int FR    = (FUSE != 0) ? NP * FW : 0;
  localparam int NROWS = FR + NP + NA + 1;

  logic [NROWS-1:0][W-1:0] pool;
  logic [NP-1:0][W-1:0]    neg_row;
  logic [W-1:0]            corr;
  logic [W-1:0]            tree_s;
  logic [W-1:0]            tree_c;

  for (genvar k = 0; k < NP; k++) begin : g_prod
    logic [FW-1:0][W-1:0] pp;
    logic [FW:0][W-1:0]   full_rows;
    logic [W-1:0]         fs;
    logic [W-1:0]         fc;
    logic [W-1:0]         full;

    fmac_ppgen #(.W(W), .FW(FW)) u_pp (
      .x   (mul_x[k*FW +: FW]),
      .y   (mul_y[k*FW +: FW]),
      .sgn (mul_signed[k]),
      .rows(pp)
    );

    // Standalone product: its own +1 for the inverted signed row.
    assign full_rows = {W'(mul_signed[k]), pp};

    fmac_csa_tree #(.W(W), .ROWS(FW + 1), .PREF42(PREF42)) u_ftree (
      .rows (full_rows),
      .row_s(fs),
      .row_c(fc)
    );

    fmac_cpa #(.W(W), .RIPPLE_BELOW(RIPPLE_BELOW)) u_fadd (
      .x(fs),
      .y(fc),
      .s(full)
    );

    assign neg_row[k] = mul_neg[k] ? ~full : ((FUSE != 0) ? '0 : full);
    assign pool[FR+k] = neg_row[k];

    if (FUSE != 0) begin : g_fuse
      for (genvar j = 0; j < FW; j++) begin : g_row
        assign pool[k*FW+j] = mul_neg[k] ? '0 : pp[j];
      end
    end
  end

  for (genvar m = 0; m < NA; m++) begin : g_add
    logic [W-1:0] ext;
    always_comb begin
      ext = '0;
      ext[AW-1:0] = addend[m*AW +: AW];
      for (int i = AW; i < W; i++) ext[i] = addend_signed[m] & addend[m*AW+AW-1];
    end
    assign pool[FR+NP+m] = addend_neg[m] ? ~ext : ext;
  end

  // One constant row collects every +1 the inverted rows need.
  always_comb begin
    corr = '0;
    for (int k = 0; k < NP; k++) begin
      corr = corr + W'(mul_neg[k]);
      if (FUSE != 0) corr = corr + W'(mul_signed[k] & ~mul_neg[k]);
    end
    for (int m = 0; m < NA; m++) corr = corr + W'(addend_neg[m]);
  end
  assign pool[NROWS-1] = corr;

  fmac_csa_tree #(.W(W), .ROWS(NROWS), .PREF42(PREF42)) u_tree (
    .rows (pool),
    .row_s(tree_s),
    .row_c(tree_c)
  );

  fmac_cpa #(.W(W), .RIPPLE_BELOW(RIPPLE_BELOW)) u_final (
    .x(tree_s),
    .y(tree_c),
    .s(total)
  );
endmodule

// File: rtl/fmac_tree_chk.sv
module fmac_tree_chk #(
  parameter int W     = 16,
  parameter int NP    = 2,
  parameter int FW    = 8,
  parameter int NA    = 2,
  parameter int AW    = 12,
  parameter int NROWS = 5
) (
  input logic [NP*FW-1:0]      mul_x,
  input logic [NP*FW-1:0]      mul_y,
  input logic [NP-1:0]         mul_signed,
  input logic [NP-1:0]         mul_neg,
  input logic [NA*AW-1:0]      addend,
  input logic [NA-1:0]         addend_signed,
  input logic [NA-1:0]         addend_neg,
  input logic [W-1:0]          total,
  input logic [NROWS-1:0][W-1:0] pool,
  input logic [NP-1:0][W-1:0]  neg_row,
  input logic [W-1:0]          tree_s,
  input logic [W-1:0]          tree_c
);
  always_comb begin
    logic [W-1:0] acc;
    logic [W-1:0] xa;
    logic [W-1:0] yb;
    logic [W-1:0] av;
    logic [W-1:0] prod;
    logic [W-1:0] psum;
    acc = '0;
    for (int k = 0; k < NP; k++) begin
      xa = '0;
      yb = '0;
      xa[FW-1:0] = mul_x[k*FW +: FW];
      yb[FW-1:0] = mul_y[k*FW +: FW];
      for (int i = FW; i < W; i++) begin
        xa[i] = mul_signed[k] & mul_x[k*FW+FW-1];
        yb[i] = mul_signed[k] & mul_y[k*FW+FW-1];
      end
      prod = xa * yb;
      if (mul_neg[k]) begin
        acc = acc - prod;
        // R6: subtracted product enters as the complement of its value
        assert_negrow_R6: assert (neg_row[k] == ~prod)
          else $error("negated product row mismatch");
      end else begin
        acc = acc + prod;
      end
    end
    for (int m = 0; m < NA; m++) begin
      av = '0;
      av[AW-1:0] = addend[m*AW +: AW];
      for (int i = AW; i < W; i++) av[i] = addend_signed[m] & addend[m*AW+AW-1];
      acc = addend_neg[m] ? acc - av : acc + av;
    end
    psum = '0;
    for (int r = 0; r < NROWS; r++) psum = psum + pool[r];
    assert_sum_R1: assert (total == acc)
      else $error("total mismatch");
    assert_conserve_R8: assert (psum == tree_s + tree_c)
      else $error("reduction changed the row sum");
    assert_final_R9: assert (total == tree_s + tree_c)
      else $error("final adder mismatch");
  end
endmodule

bind fmac_tree fmac_tree_chk #(
  .W(W), .NP(NP), .FW(FW), .NA(NA), .AW(AW), .NROWS(NROWS)
) u_chk (
  .mul_x        (mul_x),
  .mul_y        (mul_y),
  .mul_signed   (mul_signed),
  .mul_neg      (mul_neg),
  .addend       (addend),
  .addend_signed(addend_signed),
  .addend_neg   (addend_neg),
  .total        (total),
  .pool         (pool),
  .neg_row      (neg_row),
  .tree_s       (tree_s),
  .tree_c       (tree_c)
);

// File: tb/fmac_tree_test.sv
module fmac_tree_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] mx;
  logic [15:0] my;
  logic [1:0]  msg;
  logic [1:0]  mneg;
  logic [23:0] ad;
  logic [1:0]  asg;
  logic [1:0]  aneg;
  logic [15:0] tot_a;
  logic [11:0] tot_b;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  fmac_tree #(.W(16), .NP(2), .FW(8), .NA(2), .AW(12), .FUSE(1), .PREF42(1), .RIPPLE_BELOW(16)) uut (
    .mul_x(mx), .mul_y(my), .mul_signed(msg), .mul_neg(mneg),
    .addend(ad), .addend_signed(asg), .addend_neg(aneg), .total(tot_a)
  );

  fmac_tree #(.W(12), .NP(2), .FW(8), .NA(2), .AW(12), .FUSE(0), .PREF42(0), .RIPPLE_BELOW(16)) uut_b (
    .mul_x(mx), .mul_y(my), .mul_signed(msg), .mul_neg(mneg),
    .addend(ad), .addend_signed(asg), .addend_neg(aneg), .total(tot_b)
  );

  function automatic longint model(int w);
    longint acc;
    longint xv;
    longint yv;
    longint av;
    longint mask;
    acc = 0;
    for (int k = 0; k < 2; k++) begin
      xv = longint'(mx[k*8 +: 8]);
      yv = longint'(my[k*8 +: 8]);
      if (msg[k] && xv >= 128) xv = xv - 256;
      if (msg[k] && yv >= 128) yv = yv - 256;
      if (mneg[k]) acc = acc - xv * yv;
      else acc = acc + xv * yv;
    end
    for (int m = 0; m < 2; m++) begin
      av = longint'(ad[m*12 +: 12]);
      if (asg[m] && av >= 2048) av = av - 4096;
      if (aneg[m]) acc = acc - av;
      else acc = acc + av;
    end
    mask = (longint'(1) << w) - 1;
    return acc & mask;
  endfunction

  task automatic compare(string tag);
    longint ea;
    longint eb;
    ea = model(16);
    eb = model(12);
    tests++;
    if (longint'(tot_a) != ea) begin
      fails++;
      $display("FAIL %s uut: actual %h expected %h", tag, tot_a, ea[15:0]);
    end
    tests++;
    if (longint'(tot_b) != eb) begin
      fails++;
      $display("FAIL %s uut_b: actual %h expected %h", tag, tot_b, eb[11:0]);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic [1:0] s,
                       input logic [1:0] n, input logic [23:0] a, input logic [1:0] as_i,
                       input logic [1:0] an, input string tag);
    @(posedge clk);
    #1;
    mx = x; my = y; msg = s; mneg = n; ad = a; asg = as_i; aneg = an;
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [7:0] pick_factor();
    case ($urandom % 5)
      0: return 8'h80;
      1: return 8'h7F;
      2: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    mx = '0; my = '0; msg = '0; mneg = '0; ad = '0; asg = '0; aneg = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare("R10 reset zero");
    // R10: every flag set, all values zero
    apply(16'h0000, 16'h0000, 2'b11, 2'b11, 24'h000000, 2'b11, 2'b11, "R10 flags only");
    // R2: most-negative signed factors, (-128)*(-128)
    apply(16'h0080, 16'h0080, 2'b01, 2'b00, 24'h0, 2'b00, 2'b00, "R2 minneg squared");
    // R2: (-128)*127 signed
    apply(16'h0080, 16'h007F, 2'b01, 2'b00, 24'h0, 2'b00, 2'b00, "R2 minneg times max");
    // R2: same bits unsigned, 255*255
    apply(16'h00FF, 16'h00FF, 2'b00, 2'b00, 24'h0, 2'b00, 2'b00, "R2 unsigned max");
    // R4: subtracted signed product
    apply(16'h8000, 16'h8000, 2'b10, 2'b10, 24'h0, 2'b00, 2'b00, "R4 sub product");
    // R3: addend 0x800 signed versus unsigned
    apply(16'h0, 16'h0, 2'b00, 2'b00, 24'h000800, 2'b01, 2'b00, "R3 signed addend");
    apply(16'h0, 16'h0, 2'b00, 2'b00, 24'h000800, 2'b00, 2'b00, "R3 unsigned addend");
    // R4: subtracted addend
    apply(16'h0, 16'h0, 2'b00, 2'b00, 24'h123456, 2'b10, 2'b01, "R4 sub addend");
    // R5: two unsigned max products overflow W
    apply(16'hFFFF, 16'hFFFF, 2'b00, 2'b00, 24'hFFFFFF, 2'b00, 2'b00, "R5 wrap");
    // R6: subtracted unsigned products
    apply(16'hC3A5, 16'h5AFF, 2'b00, 2'b11, 24'h0, 2'b00, 2'b00, "R6 neg unsigned");
    apply(16'h8080, 16'h8080, 2'b11, 2'b11, 24'h800800, 2'b11, 2'b11, "R6 neg signed minneg");
    for (int i = 0; i < 600; i++) begin
      apply({pick_factor(), pick_factor()}, {pick_factor(), pick_factor()},
            2'($urandom), 2'($urandom), 24'($urandom), 2'($urandom), 2'($urandom),
            "R1 R7 R8 R9 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule